// File: doc/BRIEF.md
# Register Window State Counter Unit

This block tracks the state of a circular file of register windows. It does not use a mask of invalid windows. It keeps four small counters instead: windows free for a save, windows that can be restored, windows that belong to another context, and windows already cleaned. It also keeps an internal window pointer that counts downward on a save. A register-file controller pulses one operation strobe per cycle: save, restore, flush, saved or restored. The unit then either moves the pointer and updates the counters, or reports a trap with a vector code.

The trap code for a spill or a fill is shaped by a six-bit window-state input. Its low three bits pick the handler when no windows belong to another context. Its high three bits pick the handler when such windows exist, and in that case the other-context flag is also set in the code. The pointer is stored in reverse order, so the unit also gives software its view of the window number and accepts writes of that number. A write port for the counters allows privileged code to set any counter directly.

Top module: `win_state_unit`

## Requirements
- R1: After reset, the can-save counter is N-2 and the clean counter is N-1. The can-restore counter, the other counter, the internal pointer and trapValid are 0, and the architectural window number is N-1.
- R2: A save with can-save equal to 0 changes no state and raises a spill trap. When the other counter is zero, the code is 0x080 | (wstate[2:0] << 2). Otherwise it is 0x080 | 0x020 | (wstate[5:3] << 2).
- R3: A save with can-save nonzero and clean equal to can-restore changes no state and raises a trap with code 0x024.
- R4: Any other save decrements can-save and increments can-restore. It moves the internal pointer down by one, and the pointer wraps from 0 to N-1.
- R5: A restore with can-restore equal to 0 changes no state and raises a fill trap. The code is built as in R2, but with base 0x0C0. Any other restore increments can-save, decrements can-restore, and moves the pointer up by one, wrapping from N-1 to 0.
- R6: A flush raises a spill trap, coded as in R2, when can-save differs from N-2. Otherwise it changes nothing and raises no trap.
- R7: The saved operation increments can-save. It decrements the other counter if that counter is nonzero, and decrements can-restore otherwise.
- R8: The restored operation increments can-restore. It increments clean only while clean is below N-1. It decrements the other counter if that counter is nonzero, and decrements can-save otherwise.
- R9: cwpArch always equals N-1 minus cwpInt. A window-number write of value v stores N-1-(v mod N) as the internal pointer.
- R10: A counter write loads ctrWrData into the counter chosen by ctrSel. The encoding is 0 for can-save, 1 for can-restore, 2 for other and 3 for clean.
- R11: All results appear on the clock edge that samples the strobe. trapValid is high for exactly the cycle after a trapping operation, and trapCode is 0 whenever trapValid is low.
- R12: When several strobes are high in the same cycle, only one operation acts. The order of precedence is save, restore, flush, saved, restored, window-number write, counter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opSave | input | 1 | Save strobe |
| opRestore | input | 1 | Restore strobe |
| opFlush | input | 1 | Flush-windows strobe |
| opSaved | input | 1 | Saved strobe (a window was spilled) |
| opRestored | input | 1 | Restored strobe (a window was filled) |
| cwpWrEn | input | 1 | Write the architectural window number |
| cwpWrData | input | DW | Window number to write, reduced mod N |
| ctrWrEn | input | 1 | Write one counter |
| ctrSel | input | 2 | Counter select for a counter write |
| ctrWrData | input | CW | Counter write value |
| wstate | input | 6 | Handler select: [2:0] normal, [5:3] other |
| canSave | output | CW | Windows free for save |
| canRestore | output | CW | Windows available for restore |
| otherWin | output | CW | Windows owned by another context |
| cleanWin | output | CW | Clean windows |
| cwpInt | output | CW | Internal reverse-ordered pointer |
| cwpArch | output | CW | Window number as software sees it |
| trapValid | output | 1 | Trap raised by the previous operation |
| trapCode | output | 9 | Trap vector code |

## Verification
The bench builds two copies of the unit. One has N=8, a power of two, and it runs the whole vector table. It reaches every trap kind with both the normal and the other handler field, and it reaches the saturation of the clean counter and a window-number write above N. The second copy has N=5. A non-power-of-two window count shows whether the pointer wraps at N and not at the counter width, and whether a write of 7 is reduced to 2 by the modulo.

// File: rtl/win_state_pkg.sv
package win_state_pkg;
  localparam int TT_W = 9;
  localparam logic [TT_W-1:0] TT_SPILL = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL  = 9'h0C0;
  localparam logic [TT_W-1:0] TT_CLEAN = 9'h024;
  localparam logic [TT_W-1:0] TT_OTHER = 9'h020;

  typedef enum logic [2:0] {
    OP_NONE, OP_SAVE, OP_RESTORE, OP_FLUSH,
    OP_SAVED, OP_RESTORED, OP_CWPWR, OP_CTRWR
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic csInc;
    logic csDec;
    logic crInc;
    logic crDec;
    logic owDec;
    logic clInc;
    logic ptrDown;
    logic ptrUp;
    logic ptrLoad;
    logic ctrLoad;
  } winStb_t;
endpackage

// File: rtl/win_state_ctl.sv
module win_state_ctl
  import win_state_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opSave,
  input  logic            opRestore,
  input  logic            opFlush,
  input  logic            opSaved,
  input  logic            opRestored,
  input  logic            cwpWrEn,
  input  logic            ctrWrEn,
  input  logic [5:0]      wstate,
  input  logic [CW-1:0]   canSave,
  input  logic [CW-1:0]   canRestore,
  input  logic [CW-1:0]   otherWin,
  input  logic [CW-1:0]   cleanWin,
  output winStb_t         stb,
  output logic            trapValid,
  output logic [TT_W-1:0] trapCode
);
  localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);
  localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

  opKind_e opKind;
  logic trapNext;
  logic [TT_W-1:0] codeNext;
  logic otherNz;
  logic [TT_W-1:0] handlerBits;

  // Precedence decode
  always_comb begin
    if (opSave)          opKind = OP_SAVE;
    else if (opRestore)  opKind = OP_RESTORE;
    else if (opFlush)    opKind = OP_FLUSH;
    else if (opSaved)    opKind = OP_SAVED;
    else if (opRestored) opKind = OP_RESTORED;
    else if (cwpWrEn)    opKind = OP_CWPWR;
    else if (ctrWrEn)    opKind = OP_CTRWR;
    else                 opKind = OP_NONE;
  end

  assign otherNz = (otherWin != '0);

  // Handler selection bits shared by spill and fill codes
  always_comb begin
    if (otherNz) handlerBits = TT_OTHER | TT_W'({wstate[5:3], 2'b00});
    else         handlerBits = TT_W'({wstate[2:0], 2'b00});
  end

  always_comb begin
    stb = '0;
    trapNext = 1'b0;
    codeNext = '0;
    unique case (opKind)
      OP_SAVE: begin
        if (canSave == '0) begin
          trapNext = 1'b1;
          codeNext = TT_SPILL | handlerBits;
        end else if (cleanWin == canRestore) begin
          trapNext = 1'b1;
          codeNext = TT_CLEAN;
        end else begin
          stb.csDec = 1'b1;
          stb.crInc = 1'b1;
          stb.ptrDown = 1'b1;
        end
      end
      OP_RESTORE: begin
        if (canRestore == '0) begin
          trapNext = 1'b1;
          codeNext = TT_FILL | handlerBits;
        end else begin
          stb.csInc = 1'b1;
          stb.crDec = 1'b1;
          stb.ptrUp = 1'b1;
        end
      end
      OP_FLUSH: begin
        if (canSave != FLUSH_OK) begin
          trapNext = 1'b1;
          codeNext = TT_SPILL | handlerBits;
        end
      end
      OP_SAVED: begin
        stb.csInc = 1'b1;
        if (otherNz) stb.owDec = 1'b1;
        else         stb.crDec = 1'b1;
      end
      OP_RESTORED: begin
        stb.crInc = 1'b1;
        stb.clInc = (cleanWin < CLEAN_MAX);
        if (otherNz) stb.owDec = 1'b1;
        else         stb.csDec = 1'b1;
      end
      OP_CWPWR: stb.ptrLoad = 1'b1;
      OP_CTRWR: stb.ctrLoad = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapValid <= 1'b0;
      trapCode <= '0;
    end else begin
      trapValid <= trapNext;
      trapCode <= codeNext;
    end
  end
endmodule

// File: rtl/win_state_dp.sv
module win_state_dp
  import win_state_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  winStb_t       stb,
  input  logic [DW-1:0] cwpWrData,
  input  logic [1:0]    ctrSel,
  input  logic [CW-1:0] ctrWrData,
  output logic [CW-1:0] canSave,
  output logic [CW-1:0] canRestore,
  output logic [CW-1:0] otherWin,
  output logic [CW-1:0] cleanWin,
  output logic [CW-1:0] cwpInt,
  output logic [CW-1:0] cwpArch
);
  localparam int NCTR = 4;
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);
  localparam logic [CW-1:0] RST_VAL [NCTR] = '{CW'(NWIN - 2), '0, '0, CW'(NWIN - 1)};

  logic [CW-1:0] ctr [NCTR];
  logic [NCTR-1:0] incVec;
  logic [NCTR-1:0] decVec;
  logic [CW-1:0] wrReduced;

  // Counter index: 0 can-save, 1 can-restore, 2 other, 3 clean
  assign incVec = {stb.clInc, 1'b0, stb.crInc, stb.csInc};
  assign decVec = {1'b0, stb.owDec, stb.crDec, stb.csDec};

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctr[i] <= RST_VAL[i];
      end else if (stb.ctrLoad && (ctrSel == 2'(i))) begin
        ctr[i] <= ctrWrData;
      end else if (incVec[i] != decVec[i]) begin
        ctr[i] <= incVec[i] ? ctr[i] + 1'b1 : ctr[i] - 1'b1;
      end
    end
  end

  assign canSave = ctr[0];
  assign canRestore = ctr[1];
  assign otherWin = ctr[2];
  assign cleanWin = ctr[3];

  assign wrReduced = CW'(32'(cwpWrData) % NWIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cwpInt <= '0;
    end else if (stb.ptrLoad) begin
      cwpInt <= TOP - wrReduced;
    end else if (stb.ptrDown) begin
      cwpInt <= (cwpInt == '0) ? TOP : cwpInt - 1'b1;
    end else if (stb.ptrUp) begin
      cwpInt <= (cwpInt == TOP) ? '0 : cwpInt + 1'b1;
    end
  end

  assign cwpArch = TOP - cwpInt;
endmodule

// File: rtl/win_state_unit.sv
module win_state_unit
  import win_state_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opSave,
  input  logic            opRestore,
  input  logic            opFlush,
  input  logic            opSaved,
  input  logic            opRestored,
  input  logic            cwpWrEn,
  input  logic [DW-1:0]   cwpWrData,
  input  logic            ctrWrEn,
  input  logic [1:0]      ctrSel,
  input  logic [CW-1:0]   ctrWrData,
  input  logic [5:0]      wstate,
  output logic [CW-1:0]   canSave,
  output logic [CW-1:0]   canRestore,
  output logic [CW-1:0]   otherWin,
  output logic [CW-1:0]   cleanWin,
  output logic [CW-1:0]   cwpInt,
  output logic [CW-1:0]   cwpArch,
  output logic            trapValid,
  output logic [TT_W-1:0] trapCode
);
  winStb_t stb;

  win_state_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rstN(rstN),
    .opSave(opSave), .opRestore(opRestore), .opFlush(opFlush),
    .opSaved(opSaved), .opRestored(opRestored),
    .cwpWrEn(cwpWrEn), .ctrWrEn(ctrWrEn), .wstate(wstate),
    .canSave(canSave), .canRestore(canRestore),
    .otherWin(otherWin), .cleanWin(cleanWin),
    .stb(stb), .trapValid(trapValid), .trapCode(trapCode)
  );

  win_state_dp #(.NWIN(NWIN), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cwpWrData(cwpWrData), .ctrSel(ctrSel), .ctrWrData(ctrWrData),
    .canSave(canSave), .canRestore(canRestore),
    .otherWin(otherWin), .cleanWin(cleanWin),
    .cwpInt(cwpInt), .cwpArch(cwpArch)
  );
endmodule

// File: rtl/win_state_chk.sv
module win_state_chk
  import win_state_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rstN,
  input logic            opSave,
  input logic            opRestore,
  input logic            opFlush,
  input logic [CW-1:0]   canSave,
  input logic [CW-1:0]   canRestore,
  input logic [CW-1:0]   cleanWin,
  input logic [CW-1:0]   cwpInt,
  input logic [CW-1:0]   cwpArch,
  input logic            trapValid,
  input logic [TT_W-1:0] trapCode
);
  AST_SPILL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (opSave && canSave == '0) |=> (trapValid && trapCode[7:6] == 2'b10 && $stable(canSave))); // R2
  AST_CLEAN_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opSave && canSave != '0 && cleanWin == canRestore) |=> (trapValid && trapCode == 9'h024)); // R3
  AST_SAVE_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (opSave && canSave != '0 && cleanWin != canRestore)
      |=> (canSave == $past(canSave) - 1'b1 && canRestore == $past(canRestore) + 1'b1 && !trapValid)); // R4
  AST_FILL_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opRestore && !opSave && canRestore == '0) |=> (trapValid && trapCode[7:6] == 2'b11)); // R5
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opFlush && !opSave && !opRestore && canSave == CW'(NWIN - 2)) |=> !trapValid); // R6
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (32'(cwpInt) < NWIN && 32'(cwpArch) < NWIN)); // R9
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> $past(opSave || opRestore || opFlush)); // R11
  AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> trapCode == '0); // R11
endmodule

bind win_state_unit win_state_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rstN(rstN), .opSave(opSave), .opRestore(opRestore), .opFlush(opFlush),
  .canSave(canSave), .canRestore(canRestore), .cleanWin(cleanWin),
  .cwpInt(cwpInt), .cwpArch(cwpArch), .trapValid(trapValid), .trapCode(trapCode)
);

// File: tb/win_state_unit_tb.sv
module win_state_unit_tb;
  localparam int CW = 3;
  localparam int NV = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opSave = 0, opRestore = 0, opFlush = 0, opSaved = 0, opRestored = 0;
  logic cwpWrEn = 0, ctrWrEn = 0;
  logic [7:0] cwpWrData = '0;
  logic [1:0] ctrSel = '0;
  logic [CW-1:0] ctrWrData = '0;
  logic [5:0] wstate = 6'b101_011;
  logic [CW-1:0] canSave, canRestore, otherWin, cleanWin, cwpInt, cwpArch;
  logic [CW-1:0] cs5, cr5, ow5, cl5, ci5, ca5;
  logic trapValid, tv5;
  logic [8:0] trapCode, tc5;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  win_state_unit #(.NWIN(8)) u_dut (
    .clk(clk), .rstN(rstN), .opSave(opSave), .opRestore(opRestore), .opFlush(opFlush),
    .opSaved(opSaved), .opRestored(opRestored), .cwpWrEn(cwpWrEn), .cwpWrData(cwpWrData),
    .ctrWrEn(ctrWrEn), .ctrSel(ctrSel), .ctrWrData(ctrWrData), .wstate(wstate),
    .canSave(canSave), .canRestore(canRestore), .otherWin(otherWin), .cleanWin(cleanWin),
    .cwpInt(cwpInt), .cwpArch(cwpArch), .trapValid(trapValid), .trapCode(trapCode));

  win_state_unit #(.NWIN(5)) u_dut5 (
    .clk(clk), .rstN(rstN), .opSave(opSave), .opRestore(opRestore), .opFlush(opFlush),
    .opSaved(opSaved), .opRestored(opRestored), .cwpWrEn(cwpWrEn), .cwpWrData(cwpWrData),
    .ctrWrEn(ctrWrEn), .ctrSel(ctrSel), .ctrWrData(ctrWrData), .wstate(wstate),
    .canSave(cs5), .canRestore(cr5), .otherWin(ow5), .cleanWin(cl5),
    .cwpInt(ci5), .cwpArch(ca5), .trapValid(tv5), .trapCode(tc5));

  // Entry: {op, data, canSave, canRestore, otherWin, cleanWin, cwpArch, trapValid, trapCode}
  // op: 0 none, 1 save, 2 restore, 3 flush, 4 saved, 5 restored, 6 cwp write,
  //     7 counter write (ctrSel = data[4:3], value = data[2:0])
  localparam logic [35:0] VEC [NV] = '{
    {3'd3, 8'h00, 3'd6, 3'd0, 3'd0, 3'd7, 3'd7, 1'b0, 9'h000}, // R6 flush ok
    {3'd2, 8'h00, 3'd6, 3'd0, 3'd0, 3'd7, 3'd7, 1'b1, 9'h0CC}, // R5 fill normal
    {3'd1, 8'h00, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0, 1'b0, 9'h000}, // R4 save wraps
    {3'd1, 8'h00, 3'd4, 3'd2, 3'd0, 3'd7, 3'd1, 1'b0, 9'h000}, // R4
    {3'd3, 8'h00, 3'd4, 3'd2, 3'd0, 3'd7, 3'd1, 1'b1, 9'h08C}, // R6 flush spill
    {3'd2, 8'h00, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0, 1'b0, 9'h000}, // R5 restore
    {3'd1, 8'h00, 3'd4, 3'd2, 3'd0, 3'd7, 3'd1, 1'b0, 9'h000}, // R4
    {3'd7, 8'h1A, 3'd4, 3'd2, 3'd0, 3'd2, 3'd1, 1'b0, 9'h000}, // R10 clean=2
    {3'd1, 8'h00, 3'd4, 3'd2, 3'd0, 3'd2, 3'd1, 1'b1, 9'h024}, // R3 clean trap
    {3'd5, 8'h00, 3'd3, 3'd3, 3'd0, 3'd3, 3'd1, 1'b0, 9'h000}, // R8 restored
    {3'd1, 8'h00, 3'd3, 3'd3, 3'd0, 3'd3, 3'd1, 1'b1, 9'h024}, // R3
    {3'd7, 8'h12, 3'd3, 3'd3, 3'd2, 3'd3, 3'd1, 1'b0, 9'h000}, // R10 other=2
    {3'd5, 8'h00, 3'd3, 3'd4, 3'd1, 3'd4, 3'd1, 1'b0, 9'h000}, // R8 other path
    {3'd4, 8'h00, 3'd4, 3'd4, 3'd0, 3'd4, 3'd1, 1'b0, 9'h000}, // R7 other path
    {3'd7, 8'h11, 3'd4, 3'd4, 3'd1, 3'd4, 3'd1, 1'b0, 9'h000}, // R10
    {3'd7, 8'h00, 3'd0, 3'd4, 3'd1, 3'd4, 3'd1, 1'b0, 9'h000}, // R10 canSave=0
    {3'd1, 8'h00, 3'd0, 3'd4, 3'd1, 3'd4, 3'd1, 1'b1, 9'h0B4}, // R2 spill other
    {3'd2, 8'h00, 3'd1, 3'd3, 3'd1, 3'd4, 3'd0, 1'b0, 9'h000}, // R5
    {3'd7, 8'h08, 3'd1, 3'd0, 3'd1, 3'd4, 3'd0, 1'b0, 9'h000}, // R10 canRestore=0
    {3'd2, 8'h00, 3'd1, 3'd0, 3'd1, 3'd4, 3'd0, 1'b1, 9'h0F4}, // R5 fill other
    {3'd4, 8'h00, 3'd2, 3'd0, 3'd0, 3'd4, 3'd0, 1'b0, 9'h000}, // R7
    {3'd6, 8'd3,  3'd2, 3'd0, 3'd0, 3'd4, 3'd3, 1'b0, 9'h000}, // R9 write 3
    {3'd6, 8'd13, 3'd2, 3'd0, 3'd0, 3'd4, 3'd5, 1'b0, 9'h000}, // R9 13 mod 8
    {3'd7, 8'h1F, 3'd2, 3'd0, 3'd0, 3'd7, 3'd5, 1'b0, 9'h000}, // R10 clean=7
    {3'd5, 8'h00, 3'd1, 3'd1, 3'd0, 3'd7, 3'd5, 1'b0, 9'h000}, // R8 clean saturates
    {3'd1, 8'h00, 3'd0, 3'd2, 3'd0, 3'd7, 3'd6, 1'b0, 9'h000}, // R4
    {3'd2, 8'h00, 3'd1, 3'd1, 3'd0, 3'd7, 3'd5, 1'b0, 9'h000}, // R5
    {3'd4, 8'h00, 3'd2, 3'd0, 3'd0, 3'd7, 3'd5, 1'b0, 9'h000}  // R7 normal path
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(int op, logic [7:0] data);
    opSave = (op == 1); opRestore = (op == 2); opFlush = (op == 3);
    opSaved = (op == 4); opRestored = (op == 5); cwpWrEn = (op == 6); ctrWrEn = (op == 7);
    cwpWrData = data; ctrSel = data[4:3]; ctrWrData = data[2:0];
  endtask

  task automatic idle();
    opSave = 0; opRestore = 0; opFlush = 0; opSaved = 0; opRestored = 0;
    cwpWrEn = 0; ctrWrEn = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    doReset();
    // R1 reset state
    check("R1 canSave", canSave, 6);
    check("R1 canRestore", canRestore, 0);
    check("R1 otherWin", otherWin, 0);
    check("R1 cleanWin", cleanWin, 7);
    check("R1 cwpInt", cwpInt, 0);
    check("R1 cwpArch", cwpArch, 7);
    check("R1 trapValid", trapValid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      drive(int'(v[35:33]), v[32:25]);
      @(negedge clk);
      idle();
      check($sformatf("vec%0d canSave", i), canSave, v[24:22]);
      check($sformatf("vec%0d canRestore", i), canRestore, v[21:19]);
      check($sformatf("vec%0d otherWin", i), otherWin, v[18:16]);
      check($sformatf("vec%0d cleanWin", i), cleanWin, v[15:13]);
      check($sformatf("vec%0d cwpArch R9", i), cwpArch, v[12:10]);
      check($sformatf("vec%0d R9 sum", i), int'(cwpArch) + int'(cwpInt), 7);
      check($sformatf("vec%0d trapValid R11", i), trapValid, v[9]);
      check($sformatf("vec%0d trapCode", i), trapCode, v[8:0]);
    end

    // R11: trap lasts one cycle, code clears
    drive(2, 8'h00); // restore with canRestore==0 after last vector
    @(negedge clk);
    idle();
    check("R11 trap raised", trapValid, 1);
    check("R5 code", trapCode, 9'h0CC);
    @(negedge clk);
    check("R11 trap drops", trapValid, 0);
    check("R11 code zero", trapCode, 0);

    // R12: save beats restore; restored beats cwp write
    doReset();
    opSave = 1; opRestore = 1; opFlush = 1;
    @(negedge clk);
    idle();
    check("R12 save wins canSave", canSave, 5);
    check("R12 save wins arch", cwpArch, 0);
    check("R12 save wins trap", trapValid, 0);
    opRestored = 1; cwpWrEn = 1; cwpWrData = 8'd4; ctrWrEn = 1; ctrSel = 2'd2; ctrWrData = 3'd3;
    @(negedge clk);
    idle();
    check("R12 restored wins canRestore", canRestore, 2);
    check("R12 restored wins arch", cwpArch, 0);
    check("R12 ctr write ignored", otherWin, 0);
    cwpWrEn = 1; cwpWrData = 8'd2; ctrWrEn = 1; ctrSel = 2'd2; ctrWrData = 3'd3;
    @(negedge clk);
    idle();
    check("R12 cwp write wins", cwpArch, 2);
    check("R12 ctr write loses", otherWin, 0);

    // Non-power-of-two window count on u_dut5
    doReset();
    check("R1 N5 canSave", cs5, 3);
    check("R1 N5 cleanWin", cl5, 4);
    check("R1 N5 cwpArch", ca5, 4);
    drive(3, 8'h00);
    @(negedge clk);
    idle();
    check("R6 N5 flush ok", tv5, 0);
    drive(1, 8'h00);
    @(negedge clk);
    idle();
    check("R4 N5 ptr wraps to 4", ci5, 4);
    check("R9 N5 arch", ca5, 0);
    drive(2, 8'h00);
    @(negedge clk);
    idle();
    check("R5 N5 ptr wraps to 0", ci5, 0);
    drive(6, 8'd7);
    @(negedge clk);
    idle();
    check("R9 N5 write 7 mod 5", ca5, 2);
    check("R9 N5 internal", ci5, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule